// File: doc/BRIEF.md
# Line-Interface Control Port with Change Interrupt

This block drives and samples sixteen general-purpose pins that steer a bank of subscriber-line interface devices. It has two modes. In static mode every pin is an independent input or output, its direction taken from a direction vector and its level from an output vector. In multiplexed mode the top four pins become active-low select strobes. The block generates these itself in a fixed rotation over a repeating frame. The remaining twelve pins carry the data of whichever device is currently selected. Outputs are driven from that device's slice of a write vector, and inputs are captured into that device's slice of a read vector at the end of its select window.

A change detector watches the synchronized inputs in static mode and the captured device data in multiplexed mode. Any difference on a pin that is configured as an input and is not masked sets a pending flag. The flag drives an active-low interrupt meant for an open-drain pad. The flag holds until the register interface strobes a read of the I/O data.

Top module: `slic_ctl_port`

## Requirements
- R1: While `rst_n` is low, `pin_oe` is all zeros (every pin an input), `irq_n` is 1 and `dyn_rdata` is zero.
- R2: In static mode (`cfg_muxed`=0), one clock after an edge `pin_oe` equals `dir_reg` (bit set = output) and `pin_out` equals `out_reg`.
- R3: `io_rdata` shows `pin_in` through two flops: a new pin value appears after the second rising edge that samples it.
- R4: In multiplexed mode, pins 15..12 are driven outputs carrying active-low selects, with select k on pin 12+k. The frame is FRAME_LEN cycles long, split into four slots of FRAME_LEN/4 cycles. Select k is low for the first SEL_LEN cycles of slot k, and at most one select is low at a time. Select 0 first goes low after the second rising edge that samples `cfg_muxed`=1.
- R5: In multiplexed mode, `pin_oe[11:0]` follows `dir_reg[11:0]`. While select k is low, `pin_out[11:0]` equals `dyn_wdata[12k+11:12k]`; while no select is low it is zero.
- R6: At the end of select window k, the synchronized `pin_in[11:0]` is stored in `dyn_rdata[12k+11:12k]`, and that slice is otherwise unchanged.
- R7: In static mode, a change on pin i with `dir_reg[i]`=0 and `mask_reg[i]`=0 drives `irq_n` low after the third rising edge that samples the new value.
- R8: A change on a pin configured as an output, or on a pin whose `mask_reg` bit is 1, never drives `irq_n` low.
- R9: In multiplexed mode, a capture that differs from the previous capture of the same device on an unmasked input data bit drives `irq_n` low after the capture edge.
- R10: A one-cycle `io_rd` strobe returns `irq_n` to 1 after that edge, unless a new change is detected at the same edge, in which case `irq_n` stays low.
- R11: Once low, `irq_n` stays low until `io_rd` is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the frame time base |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_muxed | input | 1 | 0 = static pins, 1 = multiplexed selects and data |
| dir_reg | input | 16 | Per-pin direction, 1 = output |
| out_reg | input | 16 | Static-mode output levels |
| mask_reg | input | 16 | Per-pin interrupt mask, 1 = suppressed |
| dyn_wdata | input | 48 | Multiplexed output data, 12 bits per device |
| io_rd | input | 1 | Strobe marking a read of the I/O data register |
| pin_in | input | 16 | Pad input levels |
| pin_out | output | 16 | Pad output levels |
| pin_oe | output | 16 | Pad output enables |
| io_rdata | output | 16 | Synchronized pad levels |
| dyn_rdata | output | 48 | Captured multiplexed input data, 12 bits per device |
| irq_n | output | 1 | Active-low interrupt for an open-drain pad |

## Verification
The hardest case to reach is the multiplexed change interrupt. It depends on when an input moves relative to four rotating capture windows, and only a capture that differs from that device's own previous capture may raise it. The bench follows the frame position in its reference model and changes pad inputs only inside the gap after a window. One masked change and one unmasked change are each given a full frame to reach every device, and the interrupt is sampled afterwards. It also lines a read strobe up with the edge at which a static change is detected, to show that the new change is kept.

// File: rtl/slic_port_pkg.sv
package slic_port_pkg;

    localparam int unsigned DEF_NPIN  = 16;
    localparam int unsigned DEF_NCS   = 4;
    localparam int unsigned DEF_FRAME = 256;
    localparam int unsigned DEF_SEL   = 16;

    typedef enum logic {
        PORT_STATIC = 1'b0,
        PORT_MUXED  = 1'b1
    } port_mode_e;

endpackage

// File: rtl/slic_pin_sync.sv
module slic_pin_sync #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = din;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_o = sync_q.s2;
    assign prev_o = sync_q.s3;

endmodule

// File: rtl/slic_frame_timer.sv
module slic_frame_timer #(
    parameter int unsigned NCS       = 4,
    parameter int unsigned FRAME_LEN = 256,
    parameter int unsigned SEL_LEN   = 16,
    parameter int unsigned SLOT_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    output logic              run_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              win_o,
    output logic              cap_o
);

    localparam int unsigned SLOT_LEN = FRAME_LEN / NCS;
    localparam int unsigned OFF_W    = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;

    typedef struct packed {
        logic              run;
        logic [SLOT_W-1:0] slot;
        logic [OFF_W-1:0]  off;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!run_i) begin
            tmr_d = '0;
        end else if (!tmr_q.run) begin
            tmr_d.run  = 1'b1;
            tmr_d.slot = '0;
            tmr_d.off  = '0;
        end else if (32'(tmr_q.off) == SLOT_LEN - 1) begin
            tmr_d.off  = '0;
            tmr_d.slot = (32'(tmr_q.slot) == NCS - 1) ? '0 : tmr_q.slot + 1'b1;
        end else begin
            tmr_d.off = tmr_q.off + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign run_o  = tmr_q.run;
    assign slot_o = tmr_q.slot;
    assign win_o  = tmr_q.run && (32'(tmr_q.off) < SEL_LEN);
    assign cap_o  = tmr_q.run && (32'(tmr_q.off) == SEL_LEN - 1);

endmodule

// File: rtl/slic_irq_ctl.sv
module slic_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n_o
);

    typedef struct packed {
        logic pend;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d      = irq_q;
        irq_d.pend = (irq_q.pend && !clr_i) || set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq_n_o = ~irq_q.pend;

endmodule

// File: rtl/slic_ctl_port.sv
module slic_ctl_port
    import slic_port_pkg::*;
#(
    parameter int unsigned NPIN      = DEF_NPIN,
    parameter int unsigned NCS       = DEF_NCS,
    parameter int unsigned FRAME_LEN = DEF_FRAME,
    parameter int unsigned SEL_LEN   = DEF_SEL
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_muxed,
    input  logic [NPIN-1:0]              dir_reg,
    input  logic [NPIN-1:0]              out_reg,
    input  logic [NPIN-1:0]              mask_reg,
    input  logic [(NPIN-NCS)*NCS-1:0]    dyn_wdata,
    input  logic                         io_rd,
    input  logic [NPIN-1:0]              pin_in,
    output logic [NPIN-1:0]              pin_out,
    output logic [NPIN-1:0]              pin_oe,
    output logic [NPIN-1:0]              io_rdata,
    output logic [(NPIN-NCS)*NCS-1:0]    dyn_rdata,
    output logic                         irq_n
);

    localparam int unsigned NDATA  = NPIN - NCS;
    localparam int unsigned SLOT_W = (NCS > 1) ? $clog2(NCS) : 1;

    typedef struct packed {
        logic [NPIN-1:0]             oe;
        logic [NPIN-1:0]             out;
        logic [NCS-1:0][NDATA-1:0]   cap;
    } port_t;

    port_t port_d, port_q;

    port_mode_e                mode;
    logic [NPIN-1:0]           sync_v;
    logic [NPIN-1:0]           prev_v;
    logic [NPIN-1:0]           watch;
    logic [NPIN-1:0]           stat_hit;
    logic                      tmr_run;
    logic                      tmr_win;
    logic                      tmr_cap;
    logic [SLOT_W-1:0]         tmr_slot;
    logic                      set_any;
    logic [NCS-1:0][NDATA-1:0] cap_nxt;
    logic [NCS-1:0][NDATA-1:0] chg;
    logic [NCS-1:0]            sel_vec;
    logic [NDATA-1:0]          wslice;

    assign mode  = cfg_muxed ? PORT_MUXED : PORT_STATIC;
    assign watch = ~dir_reg & ~mask_reg;

    slic_pin_sync #(.W(NPIN)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (pin_in),
        .sync_o (sync_v),
        .prev_o (prev_v)
    );

    slic_frame_timer #(
        .NCS       (NCS),
        .FRAME_LEN (FRAME_LEN),
        .SEL_LEN   (SEL_LEN),
        .SLOT_W    (SLOT_W)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (mode == PORT_MUXED),
        .run_o  (tmr_run),
        .slot_o (tmr_slot),
        .win_o  (tmr_win),
        .cap_o  (tmr_cap)
    );

    // Per-device capture and change detection
    for (genvar k = 0; k < NCS; k++) begin : g_dev
        logic hit;
        assign hit        = tmr_cap && (tmr_slot == SLOT_W'(k));
        assign cap_nxt[k] = hit ? sync_v[NDATA-1:0] : port_q.cap[k];
        assign chg[k]     = hit ? ((sync_v[NDATA-1:0] ^ port_q.cap[k]) & watch[NDATA-1:0])
                                : {NDATA{1'b0}};
    end

    assign stat_hit = (mode == PORT_STATIC) ? ((sync_v ^ prev_v) & watch) : {NPIN{1'b0}};
    assign set_any  = (|stat_hit) || (|chg);

    always_comb begin
        port_d  = port_q;
        sel_vec = tmr_win ? (NCS'(1) << tmr_slot) : {NCS{1'b0}};
        wslice  = dyn_wdata[tmr_slot*NDATA +: NDATA];
        if (tmr_run) begin
            port_d.oe  = {{NCS{1'b1}}, dir_reg[NDATA-1:0]};
            port_d.out = {~sel_vec, (tmr_win ? wslice : {NDATA{1'b0}})};
        end else begin
            port_d.oe  = dir_reg;
            port_d.out = out_reg;
        end
        port_d.cap = cap_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) port_q <= '0;
        else        port_q <= port_d;
    end

    slic_irq_ctl u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_any),
        .clr_i   (io_rd),
        .irq_n_o (irq_n)
    );

    assign pin_oe    = port_q.oe;
    assign pin_out   = port_q.out;
    assign io_rdata  = sync_v;
    assign dyn_rdata = port_q.cap;

endmodule

// File: rtl/slic_port_chk.sv
module slic_port_chk #(
    parameter int unsigned NPIN = 16,
    parameter int unsigned NCS  = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      io_rd,
    input logic                      irq_n,
    input logic                      tmr_run,
    input logic                      tmr_cap,
    input logic                      set_any,
    input logic [NPIN-1:0]           pin_out,
    input logic [(NPIN-NCS)*NCS-1:0] dyn_rdata
);

    localparam int unsigned NDATA = NPIN - NCS;

    // R4
    sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tmr_run) |-> ($countones(~pin_out[NPIN-1:NDATA]) <= 1));

    // R6
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_cap |=> $stable(dyn_rdata));

    // R10
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !set_any) |=> irq_n);

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(set_any));

    // R11
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !io_rd) |=> !irq_n);

endmodule

bind slic_ctl_port slic_port_chk #(.NPIN(NPIN), .NCS(NCS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_rd     (io_rd),
    .irq_n     (irq_n),
    .tmr_run   (tmr_run),
    .tmr_cap   (tmr_cap),
    .set_any   (set_any),
    .pin_out   (pin_out),
    .dyn_rdata (dyn_rdata)
);

// File: tb/sim_slic_ctl_port.sv
module sim_slic_ctl_port;

    localparam int CLK_PER = 10;
    localparam int NPIN    = 16;
    localparam int NCS     = 4;
    localparam int NDATA   = 12;
    localparam int FRAME   = 256;
    localparam int SEL     = 16;
    localparam int SLOT    = FRAME / NCS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_muxed = 1'b0;
    logic [15:0] dir_reg = '0;
    logic [15:0] out_reg = '0;
    logic [15:0] mask_reg = '0;
    logic [47:0] dyn_wdata = '0;
    logic        io_rd = 1'b0;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe, io_rdata;
    logic [47:0] dyn_rdata;
    logic        irq_n;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    slic_ctl_port u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_muxed (cfg_muxed),
        .dir_reg   (dir_reg),
        .out_reg   (out_reg),
        .mask_reg  (mask_reg),
        .dyn_wdata (dyn_wdata),
        .io_rd     (io_rd),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .io_rdata  (io_rdata),
        .dyn_rdata (dyn_rdata),
        .irq_n     (irq_n)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    bit          m_en;
    int          m_off;
    int          m_slot;
    bit          m_pend;
    bit          m_muxed_out;
    logic [11:0] m_cap [4];
    logic [15:0] hist [$];
    logic [15:0] e_oe, e_out, e_rd;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_off = 0; m_slot = 0; m_pend = 0; m_muxed_out = 0;
            foreach (m_cap[i]) m_cap[i] = '0;
            hist = '{16'h0, 16'h0, 16'h0};
            e_oe = '0; e_out = '0; e_rd = '0;
        end else begin
            logic [15:0] watch;
            bit set;
            watch = ~dir_reg & ~mask_reg;
            set = 0;
            if (!cfg_muxed && (((hist[1] ^ hist[2]) & watch) != 0)) set = 1;
            if (m_en && m_off == SEL - 1) begin
                if (((hist[1][11:0] ^ m_cap[m_slot]) & watch[11:0]) != 0) set = 1;
                m_cap[m_slot] = hist[1][11:0];
            end
            m_pend = (m_pend && !io_rd) || set;
            m_muxed_out = m_en;
            if (m_en) begin
                bit win;
                win = (m_off < SEL);
                e_oe = {4'hF, dir_reg[11:0]};
                e_out[15:12] = win ? ~(4'b0001 << m_slot) : 4'hF;
                e_out[11:0]  = win ? dyn_wdata[m_slot*12 +: 12] : 12'h0;
            end else begin
                e_oe = dir_reg;
                e_out = out_reg;
            end
            e_rd = hist[0];
            hist.push_front(pin_in);
            void'(hist.pop_back());
            if (!cfg_muxed) begin
                m_en = 0; m_off = 0; m_slot = 0;
            end else if (!m_en) begin
                m_en = 1; m_off = 0; m_slot = 0;
            end else if (m_off == SLOT - 1) begin
                m_off = 0;
                m_slot = (m_slot == NCS - 1) ? 0 : m_slot + 1;
            end else begin
                m_off++;
            end
        end
    end

    function automatic logic [47:0] cap_flat();
        return {m_cap[3], m_cap[2], m_cap[1], m_cap[0]};
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            chk(m_muxed_out ? "R5 pin_oe" : "R2 pin_oe", pin_oe, e_oe);
            chk(m_muxed_out ? "R4 pin_out" : "R2 pin_out", pin_out, e_out);
            chk("R3 io_rdata", io_rdata, e_rd);
            chk("R6 dyn_rdata", dyn_rdata, cap_flat());
            chk("R11 irq_n", irq_n, !m_pend);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic read_pulse();
        @(negedge clk) io_rd = 1'b1;
        @(negedge clk) io_rd = 1'b0;
    endtask

    task automatic wait_gap();
        do @(negedge clk); while (!(m_en && m_off == SEL + 4));
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PER * 100000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [11:0] d;
        // R1 reset state
        cyc(3);
        chk("R1 pin_oe", pin_oe, 16'h0);
        chk("R1 irq_n", irq_n, 1'b1);
        chk("R1 dyn_rdata", dyn_rdata, 48'h0);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // R2 static drive
        dir_reg = 16'h00FF; out_reg = 16'h3C5A;
        cyc(2);
        chk("R2 oe", pin_oe, 16'h00FF);
        chk("R2 out", pin_out, 16'h3C5A);

        // R3, R7 latency on an input pin
        pin_in = 16'h0100;
        cyc(2);
        chk("R3 io_rdata after 2 edges", io_rdata, 16'h0100);
        chk("R7 irq_n before third edge", irq_n, 1'b1);
        cyc(1);
        chk("R7 irq_n low", irq_n, 1'b0);
        cyc(5);
        chk("R11 irq_n held", irq_n, 1'b0);
        read_pulse();
        chk("R10 irq_n cleared", irq_n, 1'b1);

        // R8 output pin and masked pin
        pin_in = 16'h0104;
        cyc(6);
        chk("R8 output pin change", irq_n, 1'b1);
        mask_reg = 16'h0200;
        cyc(1);
        pin_in = 16'h0304;
        cyc(6);
        chk("R8 masked pin change", irq_n, 1'b1);

        // R10 read coinciding with a detected change
        pin_in = 16'h0204;
        cyc(2);
        io_rd = 1'b1;
        cyc(1);
        io_rd = 1'b0;
        chk("R10 change wins over read", irq_n, 1'b0);
        read_pulse();
        chk("R10 cleared after read", irq_n, 1'b1);

        // prepare multiplexed mode
        mask_reg = 16'h0000; dir_reg = 16'h00F0;
        dyn_wdata = 48'h9AB_567_CDE_123;
        pin_in = 16'h0A03;
        cyc(5);
        read_pulse();
        cfg_muxed = 1'b1;
        cyc(1);
        chk("R4 selects not yet driven", pin_oe[15:12], 4'h0);
        cyc(1);
        chk("R4 select0 low", pin_out[15:12], 4'hE);
        chk("R4 selects driven", pin_oe[15:12], 4'hF);
        chk("R5 data oe", pin_oe[11:0], 12'h0F0);
        chk("R5 data dev0", pin_out[11:0], 12'h123);
        cyc(SEL);
        chk("R4 gap all high", pin_out[15:12], 4'hF);
        chk("R5 data idle zero", pin_out[11:0], 12'h0);
        cyc(SLOT - SEL);
        chk("R4 select1 low", pin_out[15:12], 4'hD);
        chk("R5 data dev1", pin_out[11:0], 12'hCDE);

        cyc(2 * FRAME);
        chk("R6 captures", dyn_rdata, {4{12'hA03}});
        chk("R9 first captures raise irq", irq_n, 1'b0);
        read_pulse();
        chk("R10 cleared in muxed mode", irq_n, 1'b1);

        // R8 masked input bit in muxed mode
        wait_gap();
        mask_reg = 16'h0001;
        pin_in = 16'h0A02;
        cyc(FRAME + 8);
        chk("R8 masked muxed change", irq_n, 1'b1);
        chk("R6 masked bit still captured", dyn_rdata, {4{12'hA02}});

        // R9 unmasked input bit
        wait_gap();
        pin_in = 16'h0802;
        cyc(FRAME + 8);
        chk("R9 muxed change irq", irq_n, 1'b0);
        d = 12'h802;
        chk("R9 captures updated", dyn_rdata, {d, d, d, d});
        read_pulse();

        // R8 output data bit in muxed mode
        wait_gap();
        pin_in = 16'h0822;
        cyc(FRAME + 8);
        chk("R8 output data bit change", irq_n, 1'b1);

        // back to static
        cfg_muxed = 1'b0;
        cyc(3);
        chk("R2 oe after leaving muxed", pin_oe, 16'h00F0);
        chk("R2 out after leaving muxed", pin_out, 16'h3C5A);
        cyc(2);
        finish_run();
    end

endmodule